// File: doc/BRIEF.md
# Byte-addressed I2C register slave with row-wrapping writes

This block is the serial front end of a small on-chip register and memory map. It receives SCL and SDA after synchronisation to the system clock and pulls the shared data line low through an active-high drive enable. The block detects START, repeated START and STOP conditions, compares the first byte of each transfer with a fixed 7-bit device address, and then runs a write or a read.

A write carries one pointer byte followed by any number of data bytes. The pointer byte loads an internal address counter. Each data byte appears on a one-cycle register write port, at the counter value, as soon as the slave acknowledges it. The counter then steps forward inside its 8-byte row and wraps to the first address of that row. A read starts wherever the counter was left. It fetches bytes through a register read port and steps the counter across the whole address space with no row wrap. To read from a chosen address, the master writes only the pointer byte, issues a repeated START and then reads.

Top module: `i2c_regslave`

## Requirements
- R1: The slave acknowledges the device byte 0x50 (address 0x28, bit 0 = 0 for write) and 0x51 (bit 0 = 1 for read) by holding SDA low for the whole ninth SCL pulse.
- R2: After a device byte with a different 7-bit address, the slave sends no ACK and makes no register write, even for later bytes that equal 0x50, until the next START.
- R3: In a write, the byte after the device byte loads the address counter and produces no register write.
- R4: Each later data byte is written at the counter value, and the counter then moves to the next address.
- R5: While writing, the counter wraps within its 8-byte row, so that address (base + 7) is followed by base, where base is a multiple of 8. Addresses outside the row are not written.
- R6: A read returns data from the present counter value and adds one after each byte across the full 8-bit space, so 0x1F is followed by 0x20 and 0xFF by 0x00. This applies also to a read that has no pointer byte before it.
- R7: A pointer-only write, followed by a repeated START and a read device byte, makes the read start at that pointer.
- R8: When the master answers a read byte with NACK (SDA high), the slave releases SDA and drives it no further.
- R9: The drive enable changes only while SCL is low. SDA is sampled on SCL rising edges.
- R10: A START or STOP is recognised in every state, including in the middle of a byte. It releases SDA. A STOP in the middle of a byte leaves the counter unchanged.
- R11: Each write appears on the write port as a single-cycle pulse, before any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_waddr | output | ADDR_W | Register write address |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | ADDR_W | Register read address (the counter) |
| reg_rdata | input | 8 | Register read data for reg_raddr, combinational |

## Verification
The bench sweeps every starting offset in one row with nine data bytes, so each offset wraps and then overwrites its own first address. A counter that wraps linearly, or one that never wraps, would write into the next row or leave the wrong final values. Reads that cross a row boundary and the 0xFF address would show up a read counter that borrows the write-side row wrap. A foreign address byte followed by a byte equal to 0x50, a STOP in the middle of a byte and a repeated START after a data byte each expose a slave that re-arms without a START, or that loads or writes on a truncated byte.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MADR,
    ST_MADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } rs_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_rs_busmon.sv
module i2c_rs_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = ~scl_q & scl_i;
    scl_fall  = scl_q & ~scl_i;
    start_det = scl_q & scl_i & sda_q & ~sda_i;
    stop_det  = scl_q & scl_i & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr #(
  parameter int ADDR_W    = 8,
  parameter int ROW_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc_row,
  input  logic              inc_lin,
  output logic [ADDR_W-1:0] ptr
);
  localparam int ROW_BITS = $clog2(ROW_BYTES);

  logic [ADDR_W-1:0] nxt_row;

  generate
    if (ROW_BITS == 0) begin : g_no_row
      assign nxt_row = ptr;
    end else if (ROW_BITS >= ADDR_W) begin : g_full_row
      assign nxt_row = ptr + 1'b1;
    end else begin : g_row
      localparam logic [ROW_BITS-1:0] ONE_R = 1;
      assign nxt_row = {ptr[ADDR_W-1:ROW_BITS], ptr[ROW_BITS-1:0] + ONE_R};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (load)    ptr <= ld_val;
    else if (inc_row) ptr <= nxt_row;
    else if (inc_lin) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h28,
  parameter int         ADDR_W    = 8,
  parameter int         ROW_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [7:0]        reg_wdata,
  output logic [ADDR_W-1:0] reg_raddr,
  input  logic [7:0]        reg_rdata
);
  localparam logic [3:0] LAST_RX = 4'd8;
  localparam logic [3:0] LAST_TX = 4'd7;

  logic scl_rise, scl_fall, start_det, stop_det;
  rs_state_t state;
  logic [3:0] bitcnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic rw_q, mack_q;
  logic bus_evt, rx_done, tx_done;
  logic ptr_load, ptr_inc_row, ptr_inc_lin;
  logic [ADDR_W-1:0] ptr;

  i2c_rs_busmon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign bus_evt = start_det | stop_det;
  assign rx_done = scl_fall && (bitcnt == LAST_RX) && !bus_evt;
  assign tx_done = scl_fall && (bitcnt == LAST_TX) && !bus_evt;

  always_comb begin
    ptr_load    = (state == ST_MADR) && rx_done;
    ptr_inc_row = (state == ST_WDAT) && rx_done;
    ptr_inc_lin = (state == ST_RDAT) && tx_done;
  end

  i2c_rs_ptr #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_ptr (
    .clk(clk), .rst(rst),
    .load(ptr_load), .ld_val(rx_sr[ADDR_W-1:0]),
    .inc_row(ptr_inc_row), .inc_lin(ptr_inc_lin),
    .ptr(ptr)
  );

  assign reg_raddr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_MADR, ST_WDAT: begin
            if (scl_rise && bitcnt < LAST_RX) begin
              rx_sr  <= {rx_sr[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (rx_done) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (rx_sr[7:1] == DEV_ADDR) begin
                  rw_q   <= rx_sr[0];
                  sda_oe <= 1'b1;
                  state  <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_MADR) begin
                sda_oe <= 1'b1;
                state  <= ST_MADR_ACK;
              end else begin
                sda_oe    <= 1'b1;
                reg_we    <= 1'b1;
                reg_waddr <= ptr;
                reg_wdata <= rx_sr;
                state     <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                tx_sr  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_MADR;
              end
            end
          end
          ST_MADR_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (tx_done) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RACK;
            end else if (scl_fall) begin
              tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_sr[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_sr  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                bitcnt <= '0;
                state  <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rs_chk.sv
module i2c_rs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_raddr
);
  logic scl_h, sda_h;
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_h <= 1'b1;
      sda_h <= 1'b1;
    end else begin
      scl_h <= scl_i;
      sda_h <= sda_i;
    end
  end

  wire cond_start = scl_h & scl_i & sda_h & ~sda_i;
  wire cond_stop  = scl_h & scl_i & ~sda_h & sda_i;

  // R9: drive enable moves only while SCL is low
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i));

  // R10: a STOP releases the line
  a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
    cond_stop |=> !sda_oe);

  // R10: a START releases the line and writes nothing
  a_r10_start_release: assert property (@(posedge clk) disable iff (rst)
    cond_start |=> (!sda_oe && !reg_we));

  // R11: the write strobe lasts a single cycle
  a_r11_we_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R11: writes land in the SCL-low phase of the acknowledge
  a_r11_we_scl_low: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !scl_i);

  // R6: the address counter moves only while SCL is low
  a_r6_ptr_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_raddr) |-> !$past(scl_i));
endmodule

bind i2c_regslave i2c_rs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .reg_we(reg_we), .reg_raddr(reg_raddr)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, reg_we;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;
  logic sda_line;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int wr_cnt = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int viol = 0;
  logic oe_d = 1'b0;

  always #2 clk = ~clk;

  assign sda_line  = ~(m_low | sda_oe);
  assign reg_rdata = mem[reg_raddr];

  i2c_regslave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // R9 monitor: the enable must not change while SCL is high
  always @(posedge clk) begin
    oe_d <= sda_oe;
    if (!rst && (oe_d != sda_oe) && scl) viol <= viol + 1;
  end

  task automatic chk(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start();
    m_low = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    m_low = 1'b1; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic m_stop();
    m_low = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    m_low = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q);
      scl = 1'b1;    wq(Q);
      scl = 1'b0;    wq(Q);
    end
    m_low = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    ack = ~sda_line;
    wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl = 1'b0;
    end
    wq(Q);
    m_low = give_ack; wq(Q);
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
    m_low = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] a, input logic [7:0] d, input string tag);
    logic ack;
    send_byte(d, ack);
    chk(tag, ack, 1);
    expm[a] = d;
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    int wc0;
    int base;
    for (int i = 0; i < 256; i++) expm[i] = 8'(i) ^ 8'h5A;
    wq(6);
    rst = 1'b0;
    wq(2);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R11 reset reg_we", reg_we, 0);

    // R1 R3 R4 R11: basic write
    m_start();
    send_byte(8'h50, ack); chk("R1 write addr ack", ack, 1);
    send_byte(8'h10, ack); chk("R3 pointer ack", ack, 1);
    wr_data(8'h10, 8'hA1, "R4 data ack");
    chk("R11 written before STOP", mem[8'h10], 8'hA1);
    wr_data(8'h11, 8'hA2, "R4 data ack");
    m_stop();
    chk("R4 second address", mem[8'h11], expm[8'h11]);
    chk("R4 next untouched", mem[8'h12], expm[8'h12]);

    // R5: every start offset in row 0x08, nine bytes each
    base = 8'h08;
    for (int off = 0; off < 8; off++) begin
      m_start();
      send_byte(8'h50, ack); chk("R5 dev ack", ack, 1);
      send_byte(8'(base + off), ack); chk("R5 ptr ack", ack, 1);
      for (int k = 0; k < 9; k++)
        wr_data(8'(base + ((off + k) % 8)), 8'(off * 16 + k), "R5 data ack");
      m_stop();
      for (int a = 0; a < 8; a++)
        chk("R5 row content", mem[base + a], expm[base + a]);
      chk("R5 next row untouched", mem[8'h10], expm[8'h10]);
      chk("R5 prev row untouched", mem[8'h07], expm[8'h07]);
    end

    // R7 R6: dummy write then read across a row boundary
    m_start();
    send_byte(8'h50, ack); chk("R7 dev ack", ack, 1);
    send_byte(8'h1E, ack); chk("R7 ptr ack", ack, 1);
    m_start();
    send_byte(8'h51, ack); chk("R1 read addr ack", ack, 1);
    recv_byte(1'b1, rb); chk("R7 first read", rb, expm[8'h1E]);
    recv_byte(1'b1, rb); chk("R6 second read", rb, expm[8'h1F]);
    recv_byte(1'b0, rb); chk("R6 cross row", rb, expm[8'h20]);
    wq(Q);
    chk("R8 released after NACK", sda_oe, 0);
    chk("R8 line high", sda_line, 1);
    m_stop();

    // R6: read without pointer continues
    m_start();
    send_byte(8'h51, ack); chk("R6 dev ack", ack, 1);
    recv_byte(1'b0, rb); chk("R6 continue", rb, expm[8'h21]);
    m_stop();

    // R6: wrap at top of space
    m_start();
    send_byte(8'h50, ack);
    send_byte(8'hFF, ack);
    m_start();
    send_byte(8'h51, ack); chk("R7 dev ack", ack, 1);
    recv_byte(1'b1, rb); chk("R6 top", rb, expm[8'hFF]);
    recv_byte(1'b0, rb); chk("R6 wrap to zero", rb, expm[8'h00]);
    m_stop();

    // R2: foreign address
    wc0 = wr_cnt;
    m_start();
    send_byte(8'h52, ack); chk("R2 foreign nack", ack, 0);
    send_byte(8'h30, ack); chk("R2 no ack", ack, 0);
    send_byte(8'h99, ack); chk("R2 no ack", ack, 0);
    m_stop();
    m_start();
    send_byte(8'h40, ack); chk("R2 foreign nack", ack, 0);
    send_byte(8'h50, ack); chk("R2 no rearm", ack, 0);
    send_byte(8'h30, ack); chk("R2 no ack", ack, 0);
    m_stop();
    chk("R2 no writes", wr_cnt, wc0);
    chk("R2 mem untouched", mem[8'h30], expm[8'h30]);

    // R3: pointer-only write, then plain read
    m_start();
    send_byte(8'h50, ack); chk("R2 recover ack", ack, 1);
    send_byte(8'h30, ack); chk("R3 ptr ack", ack, 1);
    m_stop();
    chk("R3 no write for pointer", wr_cnt, wc0);
    m_start();
    send_byte(8'h51, ack);
    recv_byte(1'b0, rb); chk("R3 counter loaded", rb, expm[8'h30]);
    m_stop();

    // R10: STOP in mid byte, counter untouched
    m_start();
    send_byte(8'h50, ack);
    for (int i = 7; i >= 4; i--) begin
      m_low = ~(8'h60 >> i & 8'h01); wq(Q);
      scl = 1'b1; wq(Q);
      scl = 1'b0; wq(Q);
    end
    m_stop();
    chk("R10 released after STOP", sda_oe, 0);
    m_start();
    send_byte(8'h51, ack); chk("R10 after abort ack", ack, 1);
    recv_byte(1'b0, rb); chk("R10 counter unchanged", rb, expm[8'h31]);
    m_stop();

    // R10 R11: repeated START after a data byte
    wc0 = wr_cnt;
    m_start();
    send_byte(8'h50, ack);
    send_byte(8'h40, ack);
    wr_data(8'h40, 8'h77, "R11 data ack");
    m_start();
    chk("R11 written without STOP", mem[8'h40], 8'h77);
    chk("R11 single pulse", wr_cnt, wc0 + 1);
    send_byte(8'h51, ack); chk("R10 restart ack", ack, 1);
    recv_byte(1'b0, rb); chk("R10 read after restart", rb, expm[8'h41]);
    m_stop();

    wq(4);
    chk("R9 enable stable while SCL high", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule